// File: doc/BRIEF.md
# I2C Bus Target with Optional General Call

This block is a clocked target (slave) for a two-wire I2C-style bus. It receives the open-drain clock and data lines as ordinary inputs. It samples them with the system clock, cleans them with a short glitch filter, and watches for start and stop conditions. After a start it gathers a seven-bit address and a direction bit. It acknowledges when the address is its own, or when the address is the all-zero broadcast and broadcast response is enabled.

In a write, each received byte goes to local logic with a one-cycle valid pulse. The target acknowledges the byte only if local logic is ready. When local logic is not ready, the target refuses the byte, and every byte after it, until the next start. In a read, the target takes bytes from local logic and shifts them out. When the master does not acknowledge a byte, the target stops sending. The first byte after a broadcast is flagged as the broadcast command byte. The data output is a pull-low enable only, so the target never drives the line high.

Top module: `i2c_gc_target`

## Requirements
- R1: After reset, `sda_oe`, `rx_valid`, `tx_ready` and `rx_gc_cmd` are all 0.
- R2: The first eight bits after a start are sampled on rising clock edges. They form the address, most significant bit first, followed by a direction bit (1 = read, 0 = write). The target pulls SDA low for the whole ninth clock high time only if the address is nonzero and equals `own_addr`, or if R3 applies.
- R3: Address 0 with the direction bit at 0 is acknowledged only when `gc_en` is 1. Address 0 with the direction bit at 1 is never acknowledged.
- R4: In a write, each byte (MSB first) appears on `rx_data` with a one-cycle `rx_valid` pulse, which happens only while `rx_ready` is 1. The byte is acknowledged on its ninth clock.
- R5: If `rx_ready` is 0 when the eighth data bit is sampled, no `rx_valid` is produced and the ninth clock is left released (NACK). Later bytes get neither an acknowledge nor `rx_valid` until a new start.
- R6: `rx_gc_cmd` is 1 with the first byte received after an acknowledged general call, and 0 for every other byte.
- R7: In a read, the target sends `tx_data` MSB first and pulses `tx_ready` once for each byte it takes. If `tx_valid` is 0, it sends 0xFF and does not pulse `tx_ready`.
- R8: After a master ACK on the ninth clock of a read byte, the next byte follows. After a master NACK, the target drives nothing until a start or stop.
- R9: `sda_oe` changes only while the filtered SCL is low. The level seen on SDA stays constant through each SCL high time.
- R10: A stop (SDA rising while SCL is high) returns the target to idle. Bus clocks without a new start then get no response.
- R11: A start seen during a transfer is a repeated start. It restarts address reception.
- R12: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Target address |
| gc_en | input | 1 | 1 allows the target to join general calls |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse with a received byte |
| rx_ready | input | 1 | Local logic can accept a byte |
| rx_gc_cmd | output | 1 | Marks the general call command byte |
| tx_data | input | 8 | Byte to send in a read |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | One-cycle pulse when `tx_data` is taken |

## Verification
A wrong state register or bit count appears at the bus within one byte. The acknowledge then lands on the wrong clock, or read bits come out shifted, and the master sees this on the ninth clock of that same byte. A lost general-call or busy flag shows up at the next `rx_valid` pulse: as a wrong `rx_gc_cmd` value, or as a pulse that should never have appeared. A target that fails to leave a transfer shows up when the next stray clocks after a stop or master NACK draw an acknowledge or pulled-low bits.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } tgt_state_t;

  // Address acceptance rule: own nonzero address either way, zero only as a write broadcast.
  function automatic logic addr_hit(input logic [ADDR_W-1:0] a, input logic rd,
                                    input logic [ADDR_W-1:0] own, input logic gc_on);
    return ((a != '0) && (a == own)) || ((a == '0) && gc_on && !rd);
  endfunction

  function automatic logic is_bcast(input logic [ADDR_W-1:0] a);
    return a == '0;
  endfunction

  // Byte shifted out in a read: released line when nothing is offered.
  function automatic logic [BYTE_W-1:0] tx_pick(input logic v, input logic [BYTE_W-1:0] d);
    return v ? d : '1;
  endfunction
endpackage

// File: rtl/i2ct_line_filter.sv
module i2ct_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic s1, s2;
  logic [FILT_LEN-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      hist <= '1;
      filt <= 1'b1;
    end else begin
      s1   <= raw;
      s2   <= s1;
      hist <= {hist[FILT_LEN-2:0], s2};
      if (&hist)       filt <= 1'b1;
      else if (~|hist) filt <= 1'b0;
    end
  end
endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = !scl_p && scl_f;
  assign scl_fall  = scl_p && !scl_f;
  assign start_det = scl_p && scl_f && sda_p && !sda_f;
  assign stop_det  = scl_p && scl_f && !sda_p && sda_f;
endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
  import i2ct_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_gc_cmd,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  logic [1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2ct_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .filt(filt_lines[g]));
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2ct_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  tgt_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, txsh;
  logic              rd_dir, bcast, first_byte, ack_ph, ack_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      txsh       <= '1;
      rd_dir     <= 1'b0;
      bcast      <= 1'b0;
      first_byte <= 1'b0;
      ack_ph     <= 1'b0;
      ack_ok     <= 1'b0;
      sda_oe     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_gc_cmd  <= 1'b0;
      tx_ready   <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      rx_gc_cmd <= 1'b0;
      tx_ready  <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              rd_dir <= sda_f;
              ack_ph <= 1'b0;
              if (addr_hit(shreg[ADDR_W-1:0], sda_f, own_addr, gc_en)) begin
                state      <= ST_ADDR_ACK;
                bcast      <= is_bcast(shreg[ADDR_W-1:0]);
                first_byte <= 1'b1;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (!ack_ph) begin
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
            end else begin
              ack_ph  <= 1'b0;
              bit_cnt <= '0;
              if (rd_dir) begin
                txsh     <= tx_pick(tx_valid, tx_data);
                tx_ready <= tx_valid;
                sda_oe   <= ~tx_pick(tx_valid, tx_data)[BYTE_W-1];
                state    <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX: if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              ack_ph <= 1'b0;
              ack_ok <= rx_ready;
              state  <= ST_RX_ACK;
              if (rx_ready) begin
                rx_valid   <= 1'b1;
                rx_data    <= {shreg[BYTE_W-2:0], sda_f};
                rx_gc_cmd  <= bcast && first_byte;
                first_byte <= 1'b0;
              end
            end
          end
          ST_RX_ACK: if (scl_fall) begin
            if (!ack_ph) begin
              sda_oe <= ack_ok;
              ack_ph <= 1'b1;
            end else begin
              sda_oe  <= 1'b0;
              ack_ph  <= 1'b0;
              bit_cnt <= '0;
              state   <= ack_ok ? ST_RX : ST_WAIT;
            end
          end
          ST_TX: begin
            if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
            else if (scl_fall) begin
              if (bit_cnt == ALL_BITS) begin
                sda_oe <= 1'b0;
                ack_ph <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                sda_oe <= ~txsh[BYTE_W-2];
                txsh   <= {txsh[BYTE_W-2:0], 1'b1};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise && !ack_ph) begin
              if (sda_f) begin
                state <= ST_WAIT;
              end else begin
                ack_ph   <= 1'b1;
                txsh     <= tx_pick(tx_valid, tx_data);
                tx_ready <= tx_valid;
              end
            end else if (scl_fall && ack_ph) begin
              ack_ph  <= 1'b0;
              bit_cnt <= '0;
              sda_oe  <= ~txsh[BYTE_W-1];
              state   <= ST_TX;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input tgt_state_t state,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_gc_cmd,
  input logic       tx_ready,
  input logic       tx_valid
);
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  p_quiet_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  p_hold_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  p_rx_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_ready));

  p_gc_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gc_cmd |-> rx_valid);

  p_tx_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> $past(tx_valid));

  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR) && !sda_oe);

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));
endmodule

bind i2c_gc_target i2ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .state(state), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_gc_cmd(rx_gc_cmd), .tx_ready(tx_ready),
  .tx_valid(tx_valid));

// File: tb/i2c_gc_target_test.sv
module i2c_gc_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic gc_en = 1'b1, rx_ready = 1'b1, tx_valid = 1'b1;
  logic sda_oe, rx_valid, rx_gc_cmd, tx_ready;
  logic [7:0] rx_data, tx_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  logic [7:0] rx_log [0:15];
  logic       gc_log [0:15];
  int rx_n = 0, tx_idx = 0;
  logic [7:0] tx_mem [0:3];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tx_data = tx_mem[tx_idx % 4];

  i2c_gc_target #(.FILT_LEN(3)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr(OWN), .gc_en(gc_en), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_gc_cmd(rx_gc_cmd), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready));

  always @(negedge clk) begin
    if (rx_valid && rx_n < 16) begin
      rx_log[rx_n] = rx_data;
      gc_log[rx_n] = rx_gc_cmd;
      rx_n++;
    end
    if (tx_ready) tx_idx++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    if (!scl_m) begin
      sda_m = 1'b1; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    end
    sda_m = 1'b0; wait_q(Q); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    wait_q(Q); sda_m = 1'b0; wait_q(Q); scl_m = 1'b1; wait_q(Q); sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic bus_bit(input logic b, output logic s1, output logic s2);
    wait_q(Q); sda_m = b; wait_q(Q); scl_m = 1'b1; wait_q(Q);
    s1 = sda_line; wait_q(Q - 1); s2 = sda_line; wait_q(1); scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s1, s2);
    bus_bit(1'b1, s1, s2);
    ack = !s1 && !s2;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d, output logic steady);
    logic s1, s2;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s1, s2);
      d[i] = s1;
      if (s1 != s2) steady = 1'b0;
    end
    bus_bit(!mack, s1, s2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack, steady;
    logic [7:0] d;
    int n0, t0;
    tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C; tx_mem[2] = 8'h81; tx_mem[3] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(!sda_oe && !rx_valid && !tx_ready && !rx_gc_cmd, "R1 reset outputs",
        {sda_oe, rx_valid, tx_ready, rx_gc_cmd}, 0);
    rst_n = 1'b1;
    wait_q(20);

    // R2 / R3 address sweep with broadcast enabled, write direction
    for (int a = 0; a < 128; a++) begin
      do_start();
      wr_byte({7'(a), 1'b0}, ack);
      chk(ack == (a == int'(OWN) || a == 0), "R2 address match", ack, (a == int'(OWN) || a == 0));
      do_stop();
    end
    n0 = rx_n;
    // R3 broadcast disabled
    gc_en = 1'b0;
    do_start(); wr_byte(8'h00, ack);
    chk(!ack, "R3 general call ignored when disabled", ack, 0);
    do_stop();
    gc_en = 1'b1;
    // R3 broadcast read never acknowledged
    do_start(); wr_byte(8'h01, ack);
    chk(!ack, "R3 general call read refused", ack, 0);
    do_stop();
    // R2 read to own address acknowledged
    t0 = tx_idx;
    do_start(); wr_byte({OWN, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    rd_byte(1'b0, d, steady);
    chk(d == 8'hA5, "R7 read first byte", d, 8'hA5);
    do_stop();
    chk(rx_n == n0, "R4 no rx pulse during address-only traffic", rx_n, n0);

    // R4 / R6 write of three bytes
    tx_idx = 0;
    n0 = rx_n;
    do_start(); wr_byte({OWN, 1'b0}, ack);
    wr_byte(8'h12, ack); chk(ack, "R4 byte ack", ack, 1);
    wr_byte(8'hC7, ack); chk(ack, "R4 byte ack", ack, 1);
    wr_byte(8'h00, ack); chk(ack, "R4 byte ack", ack, 1);
    do_stop();
    chk(rx_n == n0 + 3, "R4 byte count", rx_n - n0, 3);
    chk(rx_log[n0] == 8'h12 && rx_log[n0+1] == 8'hC7 && rx_log[n0+2] == 8'h00,
        "R4 byte values", {rx_log[n0], rx_log[n0+1], rx_log[n0+2]}, 24'h12C700);
    chk(!gc_log[n0] && !gc_log[n0+1], "R6 no flag on normal write", gc_log[n0], 0);

    // R6 general call command byte
    n0 = rx_n;
    do_start(); wr_byte(8'h00, ack);
    chk(ack, "R3 general call ack when enabled", ack, 1);
    wr_byte(8'h04, ack); wr_byte(8'h99, ack);
    do_stop();
    chk(rx_n == n0 + 2 && rx_log[n0] == 8'h04 && rx_log[n0+1] == 8'h99,
        "R6 broadcast bytes", rx_n - n0, 2);
    chk(gc_log[n0] && !gc_log[n0+1], "R6 flag on first byte only", {gc_log[n0], gc_log[n0+1]}, 2);

    // R5 local side busy
    n0 = rx_n;
    rx_ready = 1'b0;
    do_start(); wr_byte({OWN, 1'b0}, ack);
    chk(ack, "R5 address still acked", ack, 1);
    wr_byte(8'h55, ack);
    chk(!ack, "R5 busy byte NACK", ack, 0);
    rx_ready = 1'b1;
    wr_byte(8'h66, ack);
    chk(!ack, "R5 later byte refused", ack, 0);
    do_stop();
    chk(rx_n == n0, "R5 no rx pulse when busy", rx_n - n0, 0);

    // R7 / R8 / R9 read with master ACK then NACK
    tx_idx = 0;
    do_start(); wr_byte({OWN, 1'b1}, ack);
    rd_byte(1'b1, d, steady);
    chk(d == 8'hA5, "R7 first read byte", d, 8'hA5);
    chk(steady, "R9 data stable while SCL high", steady, 1);
    rd_byte(1'b0, d, steady);
    chk(d == 8'h3C, "R8 byte after master ACK", d, 8'h3C);
    chk(steady, "R9 data stable while SCL high", steady, 1);
    rd_byte(1'b0, d, steady);
    chk(d == 8'hFF, "R8 released after master NACK", d, 8'hFF);
    do_stop();
    chk(tx_idx == 2, "R7 tx_ready pulse count", tx_idx, 2);

    // R7 nothing offered
    tx_valid = 1'b0; t0 = tx_idx;
    do_start(); wr_byte({OWN, 1'b1}, ack);
    rd_byte(1'b0, d, steady);
    do_stop();
    chk(d == 8'hFF && tx_idx == t0, "R7 empty source sends 0xFF", d, 8'hFF);
    tx_valid = 1'b1;

    // R10 no response after stop without start
    scl_m = 1'b0;
    wr_byte({OWN, 1'b0}, ack);
    chk(!ack, "R10 idle after stop", ack, 0);
    do_stop();

    // R11 repeated start
    do_start(); wr_byte(8'h66, ack);
    chk(!ack, "R11 foreign address refused", ack, 0);
    do_start(); wr_byte({OWN, 1'b1}, ack);
    chk(ack, "R11 repeated start address ack", ack, 1);
    rd_byte(1'b0, d, steady);
    chk(d == 8'h81, "R11 read after repeated start", d, 8'h81);
    do_stop();

    // R12 short SCL glitch ignored
    do_start();
    wait_q(3); scl_m = 1'b1; wait_q(1); scl_m = 1'b0; wait_q(2);
    wr_byte({OWN, 1'b0}, ack);
    chk(ack, "R12 glitch ignored", ack, 1);
    do_stop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule